// File: doc/BRIEF.md
# Supervisor Region Permission Decoder

This block takes the configuration bits of one memory-protection region that has already been chosen as the match for an access. From those bits, the privilege the access runs at (supervisor or user), the supervisor-may-touch-user-memory flag and the access kind, it decides whether the access may proceed. Four configuration bits are used: a supervisor-ownership flag plus read, write and execute bits.

The bit patterns fall into three families:

- **Private rules** belong to one mode.
- **Shared rules** are marked by the read-clear/write-set pattern. In this family the ownership and execute bits are reused to choose between data sharing and code sharing.
- **All-ones** is a shared read-only region, and supervisor-flag-only is a reserved pattern.

Besides the single grant bit, the block reports the decoded read/write/execute rights of both modes, so that the surrounding logic and the tests can see them.

The decode is pure logic. It sits between an input register and an output register. A request accepted on one rising edge therefore gives its answer on the next rising edge. Address matching and selection among regions happen upstream. Machine-mode bypass also happens upstream.

Top module: `spd_perm_decoder`

## Requirements
- R1: A request that `req_valid` marks at rising edge n appears on the outputs, with `rsp_valid` high, after rising edge n+1. `rsp_valid` is low in every other cycle.
- R2: With the supervisor flag set and a non-shared, non-reserved pattern, the rule is supervisor-private. Supervisor rights equal the R, W and X bits, and the user rights are all zero.
- R3: With the supervisor flag clear and a pattern other than read-clear/write-set, the rule is user-private. User rights equal the R, W and X bits.
- R4: For a user-private rule, supervisor rights are {R, W, no execute} when `sum_en` is 1, and nothing when `sum_en` is 0.
- R5: Read-clear/write-set with the supervisor flag clear is shared data. The supervisor gets read and write. The user gets read only when X=0, and read and write when X=1. Neither mode gets execute.
- R6: Read-clear/write-set with the supervisor flag set is shared code. Both modes get execute and neither gets write. The supervisor also gets read when X=1.
- R7: The all-ones pattern (S=1, R=1, W=1, X=1) gives both modes read and nothing else.
- R8: The reserved pattern S=1, R=0, W=0, X=0 denies every access kind in both modes.
- R9: `acc_type` is one-hot with bit 2 = load, bit 1 = store/AMO and bit 0 = fetch. `rsp_permit` is the right of the request's mode (`priv_user`: 1 = user, 0 = supervisor) in the matching position. Rights vectors use the same bit order: 2 = read, 1 = write, 0 = execute.
- R10: While `rst_n` is low, `rsp_valid`, `rsp_permit` and both rights vectors are zero.
- R11: When `rsp_valid` is low, `rsp_permit` and both rights vectors are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| cfg_s | input | 1 | Supervisor-ownership bit of the region |
| cfg_r | input | 1 | Read bit |
| cfg_w | input | 1 | Write bit |
| cfg_x | input | 1 | Execute bit |
| priv_user | input | 1 | Effective privilege: 1 = user, 0 = supervisor |
| sum_en | input | 1 | Supervisor may use user-private regions |
| acc_type | input | 3 | One-hot access kind: [2] load, [1] store/AMO, [0] fetch |
| rsp_valid | output | 1 | Response present |
| rsp_permit | output | 1 | Access allowed |
| rsp_sup_rights | output | 3 | Supervisor rights [2] read, [1] write, [0] execute |
| rsp_usr_rights | output | 3 | User rights, same order |

## Verification
Two rules can apply to the same request in the same cycle. The user-private rule with its `sum_en` gate reads the same supervisor-flag-clear bit as the shared-data rule. The shared-data pattern must override the gate, so its supervisor rights do not depend on `sum_en`. The bench provokes this by sweeping every configuration pattern against both `sum_en` values, both privileges and all three access kinds. Each response is compared against a behavioural model, so any leak of the gate into the shared pattern shows up as a rights or grant miscompare. Bubbles mixed into back-to-back requests check that the pipeline handoff and the zeroing of idle outputs happen together.

// File: rtl/spd_pkg.sv
package spd_pkg;

  localparam int unsigned NUM_RIGHTS = 3;

  typedef enum logic [2:0] {
    K_SUP_ONLY = 3'd0,
    K_USR_ONLY = 3'd1,
    K_SH_DATA  = 3'd2,
    K_SH_CODE  = 3'd3,
    K_SH_RO    = 3'd4,
    K_RSVD     = 3'd5
  } rule_kind_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } rights_t;

  typedef struct packed {
    logic s;
    logic r;
    logic w;
    logic x;
  } cfg_t;

  localparam rights_t NO_RIGHTS = '{rd: 1'b0, wr: 1'b0, ex: 1'b0};

  function automatic rule_kind_e classify_rule(cfg_t c);
    rule_kind_e k;
    if ({c.s, c.r, c.w, c.x} == 4'b1000)      k = K_RSVD;
    else if ({c.s, c.r, c.w, c.x} == 4'b1111) k = K_SH_RO;
    else if (!c.r && c.w)                     k = c.s ? K_SH_CODE : K_SH_DATA;
    else if (c.s)                             k = K_SUP_ONLY;
    else                                      k = K_USR_ONLY;
    return k;
  endfunction

  function automatic rights_t sup_rights_of(rule_kind_e k, cfg_t c, logic sum);
    rights_t o;
    o = NO_RIGHTS;
    unique case (k)
      K_SUP_ONLY: o = '{rd: c.r, wr: c.w, ex: c.x};
      K_USR_ONLY: o = sum ? '{rd: c.r, wr: c.w, ex: 1'b0} : NO_RIGHTS;
      K_SH_DATA:  o = '{rd: 1'b1, wr: 1'b1, ex: 1'b0};
      K_SH_CODE:  o = '{rd: c.x, wr: 1'b0, ex: 1'b1};
      K_SH_RO:    o = '{rd: 1'b1, wr: 1'b0, ex: 1'b0};
      default:    o = NO_RIGHTS;
    endcase
    return o;
  endfunction

  function automatic rights_t usr_rights_of(rule_kind_e k, cfg_t c);
    rights_t o;
    o = NO_RIGHTS;
    unique case (k)
      K_USR_ONLY: o = '{rd: c.r, wr: c.w, ex: c.x};
      K_SH_DATA:  o = '{rd: 1'b1, wr: c.x, ex: 1'b0};
      K_SH_CODE:  o = '{rd: 1'b0, wr: 1'b0, ex: 1'b1};
      K_SH_RO:    o = '{rd: 1'b1, wr: 1'b0, ex: 1'b0};
      default:    o = NO_RIGHTS;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/spd_classify.sv
module spd_classify
  import spd_pkg::*;
(
  input  cfg_t       cfg,
  output rule_kind_e kind,
  output logic       is_shared
);
  always_comb begin
    kind      = classify_rule(cfg);
    is_shared = (kind == K_SH_DATA) || (kind == K_SH_CODE) || (kind == K_SH_RO);
  end
endmodule

// File: rtl/spd_mode_rights.sv
module spd_mode_rights
  import spd_pkg::*;
#(
  parameter bit FOR_USER = 1'b0
) (
  input  rule_kind_e kind,
  input  cfg_t       cfg,
  input  logic       sum,
  output rights_t    rights
);
  generate
    if (FOR_USER) begin : g_user
      logic unused_sum;
      assign unused_sum = sum;
      always_comb rights = usr_rights_of(kind, cfg);
    end else begin : g_sup
      always_comb rights = sup_rights_of(kind, cfg, sum);
    end
  endgenerate
endmodule

// File: rtl/spd_grant.sv
module spd_grant
  import spd_pkg::*;
(
  input  rights_t                 sup_rights,
  input  rights_t                 usr_rights,
  input  logic                    priv_user,
  input  logic [NUM_RIGHTS-1:0]   acc,
  output rights_t                 mode_rights,
  output logic                    permit
);
  always_comb begin
    mode_rights = priv_user ? usr_rights : sup_rights;
    permit      = |(mode_rights & acc);
  end
endmodule

// File: rtl/spd_perm_decoder.sv
module spd_perm_decoder
  import spd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  cfg_s,
  input  logic                  cfg_r,
  input  logic                  cfg_w,
  input  logic                  cfg_x,
  input  logic                  priv_user,
  input  logic                  sum_en,
  input  logic [NUM_RIGHTS-1:0] acc_type,
  output logic                  rsp_valid,
  output logic                  rsp_permit,
  output logic [NUM_RIGHTS-1:0] rsp_sup_rights,
  output logic [NUM_RIGHTS-1:0] rsp_usr_rights
);
  // input register stage
  logic                  valid_q;
  cfg_t                  cfg_q;
  logic                  priv_q;
  logic                  sum_q;
  logic [NUM_RIGHTS-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cfg_q   <= '0;
      priv_q  <= 1'b0;
      sum_q   <= 1'b0;
      acc_q   <= '0;
    end else begin
      valid_q <= req_valid;
      if (req_valid) begin
        cfg_q  <= '{s: cfg_s, r: cfg_r, w: cfg_w, x: cfg_x};
        priv_q <= priv_user;
        sum_q  <= sum_en;
        acc_q  <= acc_type;
      end
    end
  end

  // decode, with internal events named for the assertions
  rule_kind_e kind_w;
  logic       shared_w;
  rights_t    sup_w;
  rights_t    usr_w;
  rights_t    mode_w;
  logic       permit_w;

  spd_classify u_classify (
    .cfg       (cfg_q),
    .kind      (kind_w),
    .is_shared (shared_w)
  );

  spd_mode_rights #(.FOR_USER(1'b0)) u_sup_rights (
    .kind   (kind_w),
    .cfg    (cfg_q),
    .sum    (sum_q),
    .rights (sup_w)
  );

  spd_mode_rights #(.FOR_USER(1'b1)) u_usr_rights (
    .kind   (kind_w),
    .cfg    (cfg_q),
    .sum    (sum_q),
    .rights (usr_w)
  );

  spd_grant u_grant (
    .sup_rights  (sup_w),
    .usr_rights  (usr_w),
    .priv_user   (priv_q),
    .acc         (acc_q),
    .mode_rights (mode_w),
    .permit      (permit_w)
  );

  // output register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_permit     <= 1'b0;
      rsp_sup_rights <= '0;
      rsp_usr_rights <= '0;
    end else begin
      rsp_valid      <= valid_q;
      rsp_permit     <= valid_q & permit_w;
      rsp_sup_rights <= valid_q ? sup_w : '0;
      rsp_usr_rights <= valid_q ? usr_w : '0;
    end
  end

  // cycles since reset, saturating, for the latency check
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (rsp_valid == $past(req_valid, 2)));

  assert_sup_only_user_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && kind_w == K_SUP_ONLY) |-> (usr_w == NO_RIGHTS));

  assert_user_only_no_sup_exec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && kind_w == K_USR_ONLY) |-> !sup_w.ex);

  assert_shared_code_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && kind_w == K_SH_CODE) |-> (!sup_w.wr && !usr_w.wr && sup_w.ex && usr_w.ex));

  assert_shared_ro_only_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && kind_w == K_SH_RO) |-> (sup_w == usr_w && sup_w.rd && !sup_w.wr && !sup_w.ex));

  assert_reserved_denied_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && kind_w == K_RSVD) |-> (!permit_w && !shared_w));

  assert_onehot_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($countones(acc_type) == 1));

  assert_permit_backed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_permit |-> (rsp_valid && (rsp_sup_rights != '0 || rsp_usr_rights != '0)));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_permit && rsp_sup_rights == '0 && rsp_usr_rights == '0));

endmodule

// File: tb/spd_perm_decoder_test.sv
module spd_perm_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic cfg_s = 1'b0, cfg_r = 1'b0, cfg_w = 1'b0, cfg_x = 1'b0;
  logic priv_user = 1'b0, sum_en = 1'b0;
  logic [2:0] acc_type = 3'b100;
  logic rsp_valid, rsp_permit;
  logic [2:0] rsp_sup_rights, rsp_usr_rights;

  always #(CLK_PERIOD/2) clk = ~clk;

  spd_perm_decoder uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .cfg_s(cfg_s), .cfg_r(cfg_r), .cfg_w(cfg_w), .cfg_x(cfg_x),
    .priv_user(priv_user), .sum_en(sum_en), .acc_type(acc_type),
    .rsp_valid(rsp_valid), .rsp_permit(rsp_permit),
    .rsp_sup_rights(rsp_sup_rights), .rsp_usr_rights(rsp_usr_rights)
  );

  typedef struct {
    logic       v;
    logic       p;
    logic [2:0] sr;
    logic [2:0] ur;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // behavioural model: supervisor rights as {read, write, exec}
  function automatic logic [2:0] model_sup(logic s, r, w, x, sum);
    if (s && !r && !w && !x) return 3'b000;          // reserved
    if (s && r && w && x)    return 3'b100;          // shared read-only
    if (!r && w) begin
      if (!s) return 3'b110;                         // shared data
      return {x, 1'b0, 1'b1};                        // shared code
    end
    if (s) return {r, w, x};                         // supervisor-private
    if (sum) return {r, w, 1'b0};                    // user-private, SUM on
    return 3'b000;
  endfunction

  function automatic logic [2:0] model_usr(logic s, r, w, x);
    if (s && !r && !w && !x) return 3'b000;
    if (s && r && w && x)    return 3'b100;
    if (!r && w) return s ? 3'b001 : (x ? 3'b110 : 3'b100);
    if (s) return 3'b000;
    return {r, w, x};
  endfunction

  function automatic string model_tag(logic s, r, w, x, pu);
    if (s && !r && !w && !x) return "R8";
    if (s && r && w && x)    return "R7";
    if (!r && w)             return s ? "R6" : "R5";
    if (s)                   return "R2";
    return pu ? "R3" : "R4";
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] expv);
    vectors++;
    if (act !== expv) begin
      miscompares++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, expv, $time);
    end
  endtask

  // one clock: compare the oldest outstanding response, then drive the next
  task automatic step(logic v, logic s, r, w, x, pu, sm, logic [2:0] acc);
    exp_t e;
    @(negedge clk);
    if (exp_q.size() == 2) begin
      e = exp_q.pop_front();
      check("R1 valid", {3'b0, rsp_valid}, {3'b0, e.v});
      if (e.v) begin
        check({e.tag, " sup rights"}, {1'b0, rsp_sup_rights}, {1'b0, e.sr});
        check({e.tag, " usr rights"}, {1'b0, rsp_usr_rights}, {1'b0, e.ur});
        check({"R9 permit/", e.tag}, {3'b0, rsp_permit}, {3'b0, e.p});
      end else begin
        check("R11 idle", {rsp_permit, rsp_sup_rights}, 4'b0);
        check("R11 idle", {1'b0, rsp_usr_rights}, 4'b0);
      end
    end
    req_valid = v; cfg_s = s; cfg_r = r; cfg_w = w; cfg_x = x;
    priv_user = pu; sum_en = sm; acc_type = acc;
    e.v  = v;
    e.sr = v ? model_sup(s, r, w, x, sm) : 3'b000;
    e.ur = v ? model_usr(s, r, w, x) : 3'b000;
    e.p  = v && (|((pu ? e.ur : e.sr) & acc));
    e.tag = model_tag(s, r, w, x, pu);
    exp_q.push_back(e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs zero during reset
    check("R10 reset", {rsp_valid, rsp_permit, 2'b0}, 4'b0);
    check("R10 reset", {1'b0, rsp_sup_rights}, 4'b0);
    check("R10 reset", {1'b0, rsp_usr_rights}, 4'b0);
    @(negedge clk);
    rst_n = 1'b1;
    // full sweep: every pattern, both modes, both SUM values, all access kinds
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 4; m++) begin
        for (int a = 0; a < 3; a++) begin
          logic [3:0] srwx;
          srwx = p[3:0];
          step(1'b1, srwx[3], srwx[2], srwx[1], srwx[0], m[0], m[1], 3'b001 << a);
          if (((p * 12 + m * 3 + a) % 7) == 6)
            step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b100);
        end
      end
    end
    // random traffic with random bubbles
    for (int i = 0; i < 400; i++) begin
      logic [6:0] rnd;
      rnd = 7'($urandom);
      step(($urandom % 5) != 0, rnd[0], rnd[1], rnd[2], rnd[3], rnd[4], rnd[5],
           3'b001 << ($urandom % 3));
    end
    // flush
    repeat (3) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b100);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule